// File: doc/BRIEF.md
# Performance Counter Enable Register Access Trap Arbiter

This block decides what happens when software issues a system-register read or write aimed at the performance counter enable-clear register. Each request carries the five encoding fields, a read/write flag, the current exception level and a set of trap-control bits, all as plain signals. The block first checks that the encoding selects this register. It then resolves one outcome in fixed priority order: permit, undefined instruction, trap to EL1, trap to EL2 or trap to EL3.

Traps carry a fixed exception-class syndrome of 0x18. Halting debug combined with the secure-debug-disable bit turns a would-be EL3 trap into an undefined instruction. An implementation-chosen option can also raise that condition to the highest priority at EL0 to EL2. The block does not perform the register access itself. The decision is registered and appears one cycle after the request strobe.

Top module: `sysreg_trap_arb`

## Requirements
- R1: `resp_valid_o` is high in exactly the cycle after a cycle with `req_valid_i` high. After reset it is low, and `outcome_o` is 0 and `no_match_o` is 0.
- R2: An access matches only for op0=2'b11, op1=3'b011, crn=4'b1001, crm=4'b1100, op2=3'b010. A non-matching request gives `no_match_o`=1, `outcome_o`=0 and `syndrome_ec_o`=0.
- R3: For a matched request, `outcome_o` is one-hot with bit 0 permit, bit 1 undefined, bit 2 trap-EL1, bit 3 trap-EL2 and bit 4 trap-EL3.
- R4: Every trap outcome (bits 2..4) reports `syndrome_ec_o`=6'h18. Permit and undefined report 0.
- R5: At EL3 (`cur_el_i`=3) the access is always permitted.
- R6: At EL0, with the user access enable low, the access traps. It goes to EL2 when EL2 is enabled and host routing is set, and to EL1 otherwise.
- R7: At EL0 and EL1, the fine-grained trap bit traps to EL2 when EL2 is enabled and either EL3 is absent or the EL3 fine-grained enable is set. At EL0 this check also needs host mode and host routing not both set. Reads use `fg_rd_trap_i` and writes use `fg_wr_trap_i`.
- R8: After the fine-grained check, the EL2 counter trap bit traps to EL2 when EL2 is enabled. Next, the EL3 counter trap bit traps to EL3 when EL3 is present. At EL2 only the EL3 check applies.
- R9: An access that would trap to EL3 while halted with secure debug disabled is undefined instead.
- R10: At EL0 to EL2, the following conditions together give undefined ahead of every other check: halted, EL3 present, secure debug disabled, the priority option set, and the EL3 counter trap bit set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_valid_i | input | 1 | Request strobe |
| req_write_i | input | 1 | 1 = write, 0 = read |
| op0_i | input | 2 | Encoding field op0 |
| op1_i | input | 3 | Encoding field op1 |
| crn_i | input | 4 | Encoding field CRn |
| crm_i | input | 4 | Encoding field CRm |
| op2_i | input | 3 | Encoding field op2 |
| cur_el_i | input | 2 | Current exception level |
| halted_i | input | 1 | Core in halting debug state |
| sec_dbg_dis_i | input | 1 | Secure debug disabled |
| el3_present_i | input | 1 | EL3 implemented |
| el2_enabled_i | input | 1 | EL2 enabled in current security state |
| user_acc_en_i | input | 1 | EL0 access to counters enabled |
| host_route_i | input | 1 | EL2 host routing of EL0 exceptions |
| host_mode_i | input | 1 | EL2 host mode |
| fg_enable_i | input | 1 | EL3 enable for fine-grained traps |
| fg_rd_trap_i | input | 1 | Fine-grained read trap bit |
| fg_wr_trap_i | input | 1 | Fine-grained write trap bit |
| el2_cnt_trap_i | input | 1 | EL2 counter-access trap bit |
| el3_cnt_trap_i | input | 1 | EL3 counter-access trap bit |
| undef_prio_i | input | 1 | Option: halted undefined takes top priority |
| resp_valid_o | output | 1 | Decision valid |
| no_match_o | output | 1 | Encoding did not match |
| outcome_o | output | 5 | One-hot outcome |
| syndrome_ec_o | output | 6 | Exception class for traps |

## Verification
The hardest case to reach is the split between the two halted paths. The top-priority undefined and the late conversion of an EL3 trap give the same output, so they can only be told apart through a lower-priority trap that one path masks and the other does not. The stimulus sets the EL0 user enable low together with halted, secure-debug-disable and the EL3 trap bit. It then toggles only the priority option: with the option set the result is undefined, and without it the result is the EL1 trap. A parallel pair at EL1 puts the fine-grained read bit against the write bit to show that the flag selects the bit.

// File: rtl/sysreg_trap_pkg.sv
package sysreg_trap_pkg;
  localparam int unsigned OUT_W = 5;
  localparam int unsigned EC_W  = 6;

  typedef enum logic [2:0] {
    RES_PERMIT = 3'd0,
    RES_UNDEF  = 3'd1,
    RES_TRAP1  = 3'd2,
    RES_TRAP2  = 3'd3,
    RES_TRAP3  = 3'd4
  } res_e;

  typedef struct packed {
    logic halted;
    logic sec_dbg_dis;
    logic el3_present;
    logic el2_enabled;
    logic user_acc_en;
    logic host_route;
    logic host_mode;
    logic fg_enable;
    logic fg_trap;
    logic el2_cnt_trap;
    logic el3_cnt_trap;
    logic undef_prio;
  } ctl_t;
endpackage

// File: rtl/sysreg_enc_match.sv
module sysreg_enc_match #(
  parameter logic [1:0] OP0 = 2'b11,
  parameter logic [2:0] OP1 = 3'b011,
  parameter logic [3:0] CRN = 4'b1001,
  parameter logic [3:0] CRM = 4'b1100,
  parameter logic [2:0] OP2 = 3'b010
) (
  input  logic [1:0] op0_i,
  input  logic [2:0] op1_i,
  input  logic [3:0] crn_i,
  input  logic [3:0] crm_i,
  input  logic [2:0] op2_i,
  output logic       hit_o
);
  assign hit_o = (op0_i == OP0) && (op1_i == OP1) && (crn_i == CRN) &&
                 (crm_i == CRM) && (op2_i == OP2);
endmodule

// File: rtl/sysreg_trap_eval.sv
module sysreg_trap_eval
  import sysreg_trap_pkg::*;
(
  input  logic [1:0] el_i,
  input  ctl_t       ctl_i,
  output res_e       res_o
);
  res_e el3_path;
  logic early_undef;
  logic fg_gate;

  // halted with secure debug disabled converts an EL3 trap to undefined
  assign el3_path    = (ctl_i.halted && ctl_i.sec_dbg_dis) ? RES_UNDEF : RES_TRAP3;
  assign early_undef = ctl_i.halted && ctl_i.el3_present && ctl_i.sec_dbg_dis &&
                       ctl_i.undef_prio && ctl_i.el3_cnt_trap;
  assign fg_gate     = ctl_i.el2_enabled && (!ctl_i.el3_present || ctl_i.fg_enable) &&
                       ctl_i.fg_trap;

  always_comb begin
    res_o = RES_PERMIT;
    unique case (el_i)
      2'd3: res_o = RES_PERMIT;
      2'd2: begin
        if (early_undef) res_o = RES_UNDEF;
        else if (ctl_i.el3_present && ctl_i.el3_cnt_trap) res_o = el3_path;
      end
      2'd1: begin
        if (early_undef) res_o = RES_UNDEF;
        else if (fg_gate) res_o = RES_TRAP2;
        else if (ctl_i.el2_enabled && ctl_i.el2_cnt_trap) res_o = RES_TRAP2;
        else if (ctl_i.el3_present && ctl_i.el3_cnt_trap) res_o = el3_path;
      end
      default: begin
        if (early_undef) res_o = RES_UNDEF;
        else if (!ctl_i.user_acc_en)
          res_o = (ctl_i.el2_enabled && ctl_i.host_route) ? RES_TRAP2 : RES_TRAP1;
        else if (fg_gate && !(ctl_i.host_mode && ctl_i.host_route)) res_o = RES_TRAP2;
        else if (ctl_i.el2_enabled && ctl_i.el2_cnt_trap) res_o = RES_TRAP2;
        else if (ctl_i.el3_present && ctl_i.el3_cnt_trap) res_o = el3_path;
      end
    endcase
  end
endmodule

// File: rtl/sysreg_resp_reg.sv
module sysreg_resp_reg
  import sysreg_trap_pkg::*;
#(
  parameter logic [EC_W-1:0] TRAP_EC = 6'h18
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_valid_i,
  input  logic             hit_i,
  input  res_e             res_i,
  output logic             resp_valid_o,
  output logic             no_match_o,
  output logic [OUT_W-1:0] outcome_o,
  output logic [EC_W-1:0]  syndrome_ec_o
);
  logic [OUT_W-1:0] oh_d;
  logic             is_trap;

  always_comb begin
    oh_d = '0;
    if (hit_i) oh_d[res_i] = 1'b1;
  end
  assign is_trap = hit_i && (res_i inside {RES_TRAP1, RES_TRAP2, RES_TRAP3});

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      resp_valid_o  <= 1'b0;
      no_match_o    <= 1'b0;
      outcome_o     <= '0;
      syndrome_ec_o <= '0;
    end else begin
      resp_valid_o  <= req_valid_i;
      no_match_o    <= req_valid_i && !hit_i;
      outcome_o     <= req_valid_i ? oh_d : '0;
      syndrome_ec_o <= (req_valid_i && is_trap) ? TRAP_EC : '0;
    end
  end
endmodule

// File: rtl/sysreg_trap_arb.sv
module sysreg_trap_arb
  import sysreg_trap_pkg::*;
#(
  parameter logic [EC_W-1:0] TRAP_EC = 6'h18
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_valid_i,
  input  logic             req_write_i,
  input  logic [1:0]       op0_i,
  input  logic [2:0]       op1_i,
  input  logic [3:0]       crn_i,
  input  logic [3:0]       crm_i,
  input  logic [2:0]       op2_i,
  input  logic [1:0]       cur_el_i,
  input  logic             halted_i,
  input  logic             sec_dbg_dis_i,
  input  logic             el3_present_i,
  input  logic             el2_enabled_i,
  input  logic             user_acc_en_i,
  input  logic             host_route_i,
  input  logic             host_mode_i,
  input  logic             fg_enable_i,
  input  logic             fg_rd_trap_i,
  input  logic             fg_wr_trap_i,
  input  logic             el2_cnt_trap_i,
  input  logic             el3_cnt_trap_i,
  input  logic             undef_prio_i,
  output logic             resp_valid_o,
  output logic             no_match_o,
  output logic [OUT_W-1:0] outcome_o,
  output logic [EC_W-1:0]  syndrome_ec_o
);
  logic hit;
  ctl_t ctl;
  res_e res;

  assign ctl = '{
    halted:       halted_i,
    sec_dbg_dis:  sec_dbg_dis_i,
    el3_present:  el3_present_i,
    el2_enabled:  el2_enabled_i,
    user_acc_en:  user_acc_en_i,
    host_route:   host_route_i,
    host_mode:    host_mode_i,
    fg_enable:    fg_enable_i,
    fg_trap:      req_write_i ? fg_wr_trap_i : fg_rd_trap_i,
    el2_cnt_trap: el2_cnt_trap_i,
    el3_cnt_trap: el3_cnt_trap_i,
    undef_prio:   undef_prio_i
  };

  sysreg_enc_match u_match (
    .op0_i(op0_i), .op1_i(op1_i), .crn_i(crn_i), .crm_i(crm_i), .op2_i(op2_i),
    .hit_o(hit)
  );

  sysreg_trap_eval u_eval (
    .el_i(cur_el_i), .ctl_i(ctl), .res_o(res)
  );

  sysreg_resp_reg #(.TRAP_EC(TRAP_EC)) u_resp (
    .clk_i(clk_i), .rst_ni(rst_ni), .req_valid_i(req_valid_i), .hit_i(hit),
    .res_i(res), .resp_valid_o(resp_valid_o), .no_match_o(no_match_o),
    .outcome_o(outcome_o), .syndrome_ec_o(syndrome_ec_o)
  );
endmodule

// File: rtl/sysreg_trap_arb_chk.sv
module sysreg_trap_arb_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       req_valid_i,
  input logic [1:0] cur_el_i,
  input logic       halted_i,
  input logic       sec_dbg_dis_i,
  input logic       resp_valid_o,
  input logic       no_match_o,
  input logic [4:0] outcome_o,
  input logic [5:0] syndrome_ec_o
);
  assert_valid_follows_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i |=> resp_valid_o);
  assert_valid_idle_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_valid_i |=> !resp_valid_o);
  assert_nomatch_quiet_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    no_match_o |-> (outcome_o == 5'b0 && syndrome_ec_o == 6'h0));
  assert_onehot_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (resp_valid_o && !no_match_o) |-> $countones(outcome_o) == 1);
  assert_ec_trap_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (resp_valid_o && (outcome_o[4:2] != 3'b0)) |-> syndrome_ec_o == 6'h18);
  assert_ec_none_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (outcome_o[4:2] == 3'b0) |-> syndrome_ec_o == 6'h0);
  assert_el3_permit_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && cur_el_i == 2'd3) |=> (no_match_o || outcome_o == 5'b00001));
  assert_halt_no_el3_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && halted_i && sec_dbg_dis_i) |=> !outcome_o[4]);
endmodule

bind sysreg_trap_arb sysreg_trap_arb_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .req_valid_i(req_valid_i), .cur_el_i(cur_el_i),
  .halted_i(halted_i), .sec_dbg_dis_i(sec_dbg_dis_i), .resp_valid_o(resp_valid_o),
  .no_match_o(no_match_o), .outcome_o(outcome_o), .syndrome_ec_o(syndrome_ec_o)
);

// File: tb/sysreg_trap_arb_test.sv
`timescale 1ns/1ps
module sysreg_trap_arb_test;
  localparam logic [4:0] PERMIT = 5'b00001, UNDEF = 5'b00010,
                         TRAP1 = 5'b00100, TRAP2 = 5'b01000, TRAP3 = 5'b10000;

  logic clk = 0, rst_n = 0;
  logic req_valid = 0, req_write = 0;
  logic [1:0] op0; logic [2:0] op1; logic [3:0] crn, crm; logic [2:0] op2;
  logic [1:0] el;
  logic halted, sdis, el3p, el2e, uen, hroute, hmode, fgen, fgrd, fgwr, t2, t3, prio;
  logic resp_valid, no_match; logic [4:0] outcome; logic [5:0] ec;
  int checks = 0, fails = 0;
  bit done = 0;

  always #2 clk = ~clk;

  sysreg_trap_arb uut (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(req_valid), .req_write_i(req_write),
    .op0_i(op0), .op1_i(op1), .crn_i(crn), .crm_i(crm), .op2_i(op2), .cur_el_i(el),
    .halted_i(halted), .sec_dbg_dis_i(sdis), .el3_present_i(el3p), .el2_enabled_i(el2e),
    .user_acc_en_i(uen), .host_route_i(hroute), .host_mode_i(hmode), .fg_enable_i(fgen),
    .fg_rd_trap_i(fgrd), .fg_wr_trap_i(fgwr), .el2_cnt_trap_i(t2), .el3_cnt_trap_i(t3),
    .undef_prio_i(prio), .resp_valid_o(resp_valid), .no_match_o(no_match),
    .outcome_o(outcome), .syndrome_ec_o(ec)
  );

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic defaults();
    op0 = 2'b11; op1 = 3'b011; crn = 4'b1001; crm = 4'b1100; op2 = 3'b010;
    el = 2'd0; req_write = 0;
    {halted, sdis, el3p, el2e, hroute, hmode, fgen, fgrd, fgwr, t2, t3, prio} = '0;
    uen = 1;
  endtask

  // drive at negedge, result registered at next posedge, sample at following negedge
  task automatic issue(string tag, logic [4:0] exp_oc, logic exp_nm = 0);
    req_valid = 1;
    @(negedge clk);
    req_valid = 0;
    chk({tag, " valid R1"}, resp_valid, 1);
    chk({tag, " nomatch R2"}, no_match, exp_nm);
    chk({tag, " outcome R3"}, outcome, exp_oc);
    chk({tag, " ec R4"}, ec, (exp_oc[4:2] != 0) ? 6'h18 : 6'h0);
    @(negedge clk);
    chk({tag, " idle R1"}, resp_valid, 0);
  endtask

  task automatic t_reset();
    chk("reset valid R1", resp_valid, 0);
    chk("reset outcome R1", outcome, 0);
    chk("reset nomatch R1", no_match, 0);
  endtask

  task automatic t_encoding();
    defaults(); issue("match R2", PERMIT);
    defaults(); op2 = 3'b001; issue("op2 miss R2", 5'b0, 1);
    defaults(); crm = 4'b1101; issue("crm miss R2", 5'b0, 1);
    defaults(); op0 = 2'b10; issue("op0 miss R2", 5'b0, 1);
  endtask

  task automatic t_el3();
    defaults(); el = 2'd3;
    {halted, sdis, el3p, el2e, fgen, fgrd, t2, t3, prio} = '1; uen = 0;
    issue("el3 R5", PERMIT);
  endtask

  task automatic t_user_en();
    defaults(); uen = 0; issue("el0 uen EL1 R6", TRAP1);
    defaults(); uen = 0; el2e = 1; hroute = 1; issue("el0 uen EL2 R6", TRAP2);
    defaults(); uen = 0; hroute = 1; issue("el0 uen no el2 R6", TRAP1);
  endtask

  task automatic t_fine_grain();
    defaults(); el = 2'd1; el2e = 1; fgrd = 1; issue("el1 fg rd R7", TRAP2);
    defaults(); el = 2'd1; el2e = 1; fgrd = 1; req_write = 1; issue("el1 fg wr ignore rd R7", PERMIT);
    defaults(); el = 2'd1; el2e = 1; fgwr = 1; req_write = 1; issue("el1 fg wr R7", TRAP2);
    defaults(); el = 2'd1; el2e = 1; el3p = 1; fgrd = 1; issue("el1 fg gated R7", PERMIT);
    defaults(); el = 2'd1; el2e = 1; el3p = 1; fgen = 1; fgrd = 1; issue("el1 fg en R7", TRAP2);
    defaults(); el2e = 1; hmode = 1; hroute = 1; fgrd = 1; issue("el0 fg host R7", PERMIT);
    defaults(); el2e = 1; hmode = 1; fgrd = 1; issue("el0 fg R7", TRAP2);
  endtask

  task automatic t_counter_traps();
    defaults(); el = 2'd1; el2e = 1; t2 = 1; t3 = 1; el3p = 1; issue("el1 t2 R8", TRAP2);
    defaults(); el = 2'd1; t2 = 1; issue("el1 t2 no el2 R8", PERMIT);
    defaults(); el = 2'd1; el3p = 1; t3 = 1; issue("el1 t3 R8", TRAP3);
    defaults(); el = 2'd2; el2e = 1; t2 = 1; fgrd = 1; issue("el2 ignores t2 R8", PERMIT);
    defaults(); el = 2'd2; el3p = 1; t3 = 1; issue("el2 t3 R8", TRAP3);
    defaults(); t3 = 1; issue("el0 t3 no el3 R8", PERMIT);
  endtask

  task automatic t_halted();
    defaults(); el = 2'd1; el3p = 1; t3 = 1; halted = 1; sdis = 1; issue("el1 halt R9", UNDEF);
    defaults(); el = 2'd2; el3p = 1; t3 = 1; halted = 1; issue("el2 halt no sdis R9", TRAP3);
    defaults(); uen = 0; el3p = 1; t3 = 1; halted = 1; sdis = 1; prio = 1;
    issue("el0 prio undef R10", UNDEF);
    defaults(); uen = 0; el3p = 1; t3 = 1; halted = 1; sdis = 1;
    issue("el0 no prio R10", TRAP1);
    defaults(); el = 2'd1; el2e = 1; fgrd = 1; el3p = 1; fgen = 1; t3 = 1;
    halted = 1; sdis = 1; prio = 1; issue("el1 prio over fg R10", UNDEF);
  endtask

  initial begin
    defaults();
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1;
    @(negedge clk);
    t_encoding();
    t_el3();
    t_user_en();
    t_fine_grain();
    t_counter_traps();
    t_halted();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule